// File: doc/BRIEF.md
# Auxiliary Memory Bank Switch Controller

This block sits beside a processor on a 16-bit address bus. It watches a small page of soft-switch addresses and holds a set of one-bit mode flags. It uses those flags to tell the memory system whether main RAM or auxiliary RAM should answer each read and each write in the lower part of a 64 KB space. The zero-page/stack area, the general low region and the text-display page are steered separately. When the display-steering mode is on, the text page follows the display-page flag, and the general read and write flags no longer apply to it.

Six of the flags can be read back in bit 7 of a status byte. The column-width, glyph-set and display-page flags are brought out as level outputs for the video side. The bank-select outputs are combinational from the current flags and the address of the access in progress. A switch access therefore steers the access that follows it, and never itself.

Top module: `abank_ctrl`

## Requirements
- R1: After reset every flag is 0, so all status reads return 0x00, both bank selects are 0 (main RAM), and col_wide, glyph_alt and page_two are 0.
- R2: A write to 0xC000–0xC00F updates one flag. The switch index is address bits 3:1 and the new value is address bit 0. Index 0 is display steering, 1 is read-aux, 2 is write-aux, 3 is internal slot ROM, 4 is zero-page aux, 5 is slot-3 internal, 6 is col_wide and 7 is glyph_alt. Reads of these addresses change no flag.
- R3: The internal-slot-ROM flag has inverted polarity: an even address sets it and an odd address clears it.
- R4: A read of 0x0200–0xBFFF selects aux (bank_rd_aux=1) exactly when read-aux is 1. A write to that range selects aux (bank_wr_aux=1) exactly when write-aux is 1.
- R5: While display steering is 1, reads and writes of 0x0400–0x07FF select aux exactly when page_two is 1, whatever read-aux and write-aux hold.
- R6: Reads and writes of 0x0000–0x01FF select aux exactly when zero-page aux is 1.
- R7: A read or a write of 0xC055 sets page_two, and a read or a write of 0xC054 clears it.
- R8: A read of 0xC013–0xC018 returns, in bit 7 and in address order, read-aux, write-aux, internal slot ROM, zero-page aux, slot-3 internal and display steering. Its bits 6:0 are 0. Every other read returns 0x00.
- R9: Addresses 0xC000–0xFFFF always select main RAM. A select is 0 while its strobe is low.
- R10: A flag changed by an access takes effect from the next access. The access that changes it still sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Address of the current access |
| rd_en | input | 1 | Read strobe for this cycle |
| wr_en | input | 1 | Write strobe for this cycle |
| stat_data | output | 8 | Status byte for reads |
| bank_rd_aux | output | 1 | Current read is served by auxiliary RAM |
| bank_wr_aux | output | 1 | Current write is served by auxiliary RAM |
| col_wide | output | 1 | Wide-column mode flag |
| glyph_alt | output | 1 | Alternate glyph set flag |
| page_two | output | 1 | Display page flag |

## Verification
A flag update and the steering of the next access meet at the same clock edge. A switch write commits at the edge that also starts the following access. The bench provokes this by issuing a switch write and then, in the very next cycle, a RAM access that the new flag should steer. It judges the result by sampling the select mid-cycle on both sides: on the old flag during the switch cycle and on the new flag in the following cycle. The text page adds a second overlap, because the display-steering flag, the page flag and the general read/write flags all bear on one select. The bench sets these flags in conflicting combinations and expects only the page flag to decide.

// File: rtl/abank_pkg.sv
package abank_pkg;

    typedef struct packed {
        logic store_txt;
        logic rd_aux;
        logic wr_aux;
        logic int_slot;
        logic zp_aux;
        logic slot3_int;
        logic col_wide;
        logic glyph_alt;
        logic page_two;
    } mode_t;

    localparam int unsigned SW_STORE = 0;
    localparam int unsigned SW_RDAUX = 1;
    localparam int unsigned SW_WRAUX = 2;
    localparam int unsigned SW_INTSL = 3;
    localparam int unsigned SW_ZPAUX = 4;
    localparam int unsigned SW_SLOT3 = 5;
    localparam int unsigned SW_WIDE  = 6;
    localparam int unsigned SW_GLYPH = 7;

endpackage

// File: rtl/abank_decode.sv
module abank_decode #(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] SW_BASE = 16'hC000,
    parameter logic [ADDR_W-1:0] PG_BASE = 16'hC054,
    parameter logic [ADDR_W-1:0] ST_BASE = 16'hC013,
    parameter int unsigned ST_COUNT = 6,
    parameter int unsigned IDX_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic              sw_wr,
    output logic [2:0]        sw_idx,
    output logic              sw_val,
    output logic              pg_hit,
    output logic              pg_val,
    output logic              st_hit,
    output logic [IDX_W-1:0]  st_idx
);
    localparam logic [ADDR_W-1:0] ST_LAST = ST_BASE + ADDR_W'(ST_COUNT - 1);

    always_comb begin
        sw_wr  = wr_en && (addr[ADDR_W-1:4] == SW_BASE[ADDR_W-1:4]);
        sw_idx = addr[3:1];
        sw_val = addr[0];
        pg_hit = (rd_en || wr_en) && (addr[ADDR_W-1:1] == PG_BASE[ADDR_W-1:1]);
        pg_val = addr[0];
        st_hit = rd_en && (addr >= ST_BASE) && (addr <= ST_LAST);
        st_idx = addr[IDX_W-1:0] - ST_BASE[IDX_W-1:0];
    end
endmodule

// File: rtl/abank_flags.sv
module abank_flags
    import abank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_wr,
    input  logic [2:0] sw_idx,
    input  logic       sw_val,
    input  logic       pg_hit,
    input  logic       pg_val,
    output mode_t      mode_q
);
    mode_t mode_d;

    always_comb begin
        mode_d = mode_q;
        if (sw_wr) begin
            case (32'(sw_idx))
                SW_STORE: mode_d.store_txt = sw_val;
                SW_RDAUX: mode_d.rd_aux    = sw_val;
                SW_WRAUX: mode_d.wr_aux    = sw_val;
                SW_INTSL: mode_d.int_slot  = ~sw_val;
                SW_ZPAUX: mode_d.zp_aux    = sw_val;
                SW_SLOT3: mode_d.slot3_int = sw_val;
                SW_WIDE:  mode_d.col_wide  = sw_val;
                default:  mode_d.glyph_alt = sw_val;
            endcase
        end
        if (pg_hit) begin
            mode_d.page_two = pg_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end
endmodule

// File: rtl/abank_steer.sv
module abank_steer #(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] ZP_END  = 16'h01FF,
    parameter logic [ADDR_W-1:0] LOW_END = 16'hBFFF,
    parameter logic [ADDR_W-1:0] TXT_LO  = 16'h0400,
    parameter logic [ADDR_W-1:0] TXT_HI  = 16'h07FF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              rd_aux,
    input  logic              wr_aux,
    input  logic              zp_aux,
    input  logic              store_txt,
    input  logic              page_two,
    output logic              bank_rd_aux,
    output logic              bank_wr_aux
);
    localparam int unsigned NPATH = 2;

    logic in_zp, in_low, in_txt;
    logic [NPATH-1:0] strobe, gen_flag, sel;

    always_comb begin
        in_zp    = (addr <= ZP_END);
        in_low   = (addr > ZP_END) && (addr <= LOW_END);
        in_txt   = (addr >= TXT_LO) && (addr <= TXT_HI);
        strobe   = {wr_en, rd_en};
        gen_flag = {wr_aux, rd_aux};
    end

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        always_comb begin
            if (!strobe[p]) begin
                sel[p] = 1'b0;
            end else if (in_zp) begin
                sel[p] = zp_aux;
            end else if (in_txt && store_txt) begin
                sel[p] = page_two;
            end else if (in_low) begin
                sel[p] = gen_flag[p];
            end else begin
                sel[p] = 1'b0;
            end
        end
    end

    assign bank_rd_aux = sel[0];
    assign bank_wr_aux = sel[1];
endmodule

// File: rtl/abank_status.sv
module abank_status #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ST_COUNT = 6,
    parameter int unsigned IDX_W = 3
) (
    input  logic                st_hit,
    input  logic [IDX_W-1:0]    st_idx,
    input  logic [ST_COUNT-1:0] flags,
    output logic [DATA_W-1:0]   stat_data
);
    localparam int unsigned NSLOT = 2 ** IDX_W;

    logic [NSLOT-1:0] slots;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        if (s < ST_COUNT) begin : g_used
            assign slots[s] = flags[s];
        end else begin : g_pad
            assign slots[s] = 1'b0;
        end
    end

    always_comb begin
        stat_data = '0;
        if (st_hit) begin
            stat_data[DATA_W-1] = slots[st_idx];
        end
    end
endmodule

// File: rtl/abank_ctrl.sv
module abank_ctrl
    import abank_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic [DATA_W-1:0] stat_data,
    output logic              bank_rd_aux,
    output logic              bank_wr_aux,
    output logic              col_wide,
    output logic              glyph_alt,
    output logic              page_two
);
    localparam int unsigned ST_COUNT = 6;
    localparam int unsigned IDX_W    = $clog2(ST_COUNT);

    logic             sw_wr, sw_val, pg_hit, pg_val, st_hit;
    logic [2:0]       sw_idx;
    logic [IDX_W-1:0] st_idx;
    mode_t            mode_q;
    logic [ST_COUNT-1:0] st_flags;

    abank_decode #(
        .ADDR_W(ADDR_W), .ST_COUNT(ST_COUNT), .IDX_W(IDX_W)
    ) u_decode (
        .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .sw_wr(sw_wr), .sw_idx(sw_idx), .sw_val(sw_val),
        .pg_hit(pg_hit), .pg_val(pg_val),
        .st_hit(st_hit), .st_idx(st_idx)
    );

    abank_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .sw_wr(sw_wr), .sw_idx(sw_idx), .sw_val(sw_val),
        .pg_hit(pg_hit), .pg_val(pg_val),
        .mode_q(mode_q)
    );

    abank_steer #(.ADDR_W(ADDR_W)) u_steer (
        .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .rd_aux(mode_q.rd_aux), .wr_aux(mode_q.wr_aux),
        .zp_aux(mode_q.zp_aux), .store_txt(mode_q.store_txt),
        .page_two(mode_q.page_two),
        .bank_rd_aux(bank_rd_aux), .bank_wr_aux(bank_wr_aux)
    );

    assign st_flags = {mode_q.store_txt, mode_q.slot3_int, mode_q.zp_aux,
                       mode_q.int_slot, mode_q.wr_aux, mode_q.rd_aux};

    abank_status #(
        .DATA_W(DATA_W), .ST_COUNT(ST_COUNT), .IDX_W(IDX_W)
    ) u_status (
        .st_hit(st_hit), .st_idx(st_idx), .flags(st_flags),
        .stat_data(stat_data)
    );

    assign col_wide  = mode_q.col_wide;
    assign glyph_alt = mode_q.glyph_alt;
    assign page_two  = mode_q.page_two;
endmodule

// File: rtl/abank_ctrl_chk.sv
module abank_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        rd_en,
    input logic        wr_en,
    input logic [7:0]  stat_data,
    input logic        bank_rd_aux,
    input logic        bank_wr_aux,
    input logic        col_wide,
    input logic        glyph_alt,
    input logic        page_two,
    input logic        store_on
);
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!col_wide && !glyph_alt && !page_two && !store_on));

    a_r2_wide_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && addr == 16'hC00D) |=> col_wide);

    a_r2_glyph_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && addr == 16'hC00E) |=> !glyph_alt);

    a_r5_text_page: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && store_on && addr >= 16'h0400 && addr <= 16'h07FF)
            |-> (bank_rd_aux == page_two));

    a_r7_page_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && addr == 16'hC055) |=> page_two);

    a_r8_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (stat_data[6:0] == 7'd0));

    a_r9_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rd_en |-> !bank_rd_aux) and (!wr_en |-> !bank_wr_aux)));
endmodule

bind abank_ctrl abank_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .stat_data(stat_data), .bank_rd_aux(bank_rd_aux), .bank_wr_aux(bank_wr_aux),
    .col_wide(col_wide), .glyph_alt(glyph_alt), .page_two(page_two),
    .store_on(mode_q.store_txt)
);

// File: tb/abank_ctrl_tb.sv
module abank_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  stat_data;
    logic        bank_rd_aux, bank_wr_aux, col_wide, glyph_alt, page_two;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    abank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .stat_data(stat_data), .bank_rd_aux(bank_rd_aux), .bank_wr_aux(bank_wr_aux),
        .col_wide(col_wide), .glyph_alt(glyph_alt), .page_two(page_two)
    );

    // vector: {req[3:0], op[1:0] (0 idle, 1 read, 2 write), addr, exp rd sel, exp wr sel, exp status}
    localparam int NV = 40;
    localparam logic [31:0] VEC [NV] = '{
        {4'd1, 2'd1, 16'hC013, 1'b0, 1'b0, 8'h00}, // R1 status clear
        {4'd1, 2'd1, 16'h0800, 1'b0, 1'b0, 8'h00}, // R1 main read
        {4'd1, 2'd2, 16'h0800, 1'b0, 1'b0, 8'h00}, // R1 main write
        {4'd2, 2'd2, 16'hC003, 1'b0, 1'b0, 8'h00}, // R2 set read-aux
        {4'd10,2'd1, 16'h0800, 1'b1, 1'b0, 8'h00}, // R10 R4 next access sees it
        {4'd4, 2'd2, 16'h0800, 1'b0, 1'b0, 8'h00}, // R4 write still main
        {4'd8, 2'd1, 16'hC013, 1'b0, 1'b0, 8'h80}, // R8 read-aux status
        {4'd2, 2'd2, 16'hC005, 1'b0, 1'b0, 8'h00}, // R2 set write-aux
        {4'd4, 2'd2, 16'h2100, 1'b0, 1'b1, 8'h00}, // R4 write aux
        {4'd8, 2'd1, 16'hC014, 1'b0, 1'b0, 8'h80}, // R8 write-aux status
        {4'd3, 2'd2, 16'hC006, 1'b0, 1'b0, 8'h00}, // R3 even sets
        {4'd3, 2'd1, 16'hC015, 1'b0, 1'b0, 8'h80}, // R3 status set
        {4'd3, 2'd2, 16'hC007, 1'b0, 1'b0, 8'h00}, // R3 odd clears
        {4'd3, 2'd1, 16'hC015, 1'b0, 1'b0, 8'h00}, // R3 status clear
        {4'd2, 2'd1, 16'hC001, 1'b0, 1'b0, 8'h00}, // R2 read of switch ignored
        {4'd2, 2'd1, 16'hC018, 1'b0, 1'b0, 8'h00}, // R2 steering still off
        {4'd2, 2'd2, 16'hC001, 1'b0, 1'b0, 8'h00}, // R2 set steering
        {4'd5, 2'd1, 16'h0500, 1'b0, 1'b0, 8'h00}, // R5 page 1 overrides read-aux
        {4'd5, 2'd2, 16'h0500, 1'b0, 1'b0, 8'h00}, // R5 page 1 overrides write-aux
        {4'd7, 2'd1, 16'hC055, 1'b0, 1'b0, 8'h00}, // R7 read sets page
        {4'd5, 2'd1, 16'h0500, 1'b1, 1'b0, 8'h00}, // R5 text read aux
        {4'd5, 2'd2, 16'h07FF, 1'b0, 1'b1, 8'h00}, // R5 text write aux
        {4'd5, 2'd1, 16'h0800, 1'b1, 1'b0, 8'h00}, // R5 outside text: read-aux
        {4'd2, 2'd2, 16'hC002, 1'b0, 1'b0, 8'h00}, // R2 clear read-aux
        {4'd5, 2'd1, 16'h0400, 1'b1, 1'b0, 8'h00}, // R5 still page driven
        {4'd7, 2'd2, 16'hC054, 1'b0, 1'b0, 8'h00}, // R7 write clears page
        {4'd5, 2'd2, 16'h0400, 1'b0, 1'b0, 8'h00}, // R5 page 1 though write-aux
        {4'd8, 2'd1, 16'hC018, 1'b0, 1'b0, 8'h80}, // R8 steering status
        {4'd6, 2'd1, 16'h01FF, 1'b0, 1'b0, 8'h00}, // R6 zp main
        {4'd2, 2'd2, 16'hC009, 1'b0, 1'b0, 8'h00}, // R2 set zp aux
        {4'd6, 2'd1, 16'h0000, 1'b1, 1'b0, 8'h00}, // R6 zp read aux
        {4'd6, 2'd2, 16'h01FF, 1'b0, 1'b1, 8'h00}, // R6 zp write aux
        {4'd8, 2'd1, 16'hC016, 1'b0, 1'b0, 8'h80}, // R8 zp status
        {4'd9, 2'd1, 16'hD000, 1'b0, 1'b0, 8'h00}, // R9 high read main
        {4'd9, 2'd2, 16'hE000, 1'b0, 1'b0, 8'h00}, // R9 high write main
        {4'd2, 2'd2, 16'hC00B, 1'b0, 1'b0, 8'h00}, // R2 set slot3
        {4'd8, 2'd1, 16'hC017, 1'b0, 1'b0, 8'h80}, // R8 slot3 status
        {4'd8, 2'd1, 16'hC012, 1'b0, 1'b0, 8'h00}, // R8 below window
        {4'd8, 2'd1, 16'hC019, 1'b0, 1'b0, 8'h00}, // R8 above window
        {4'd9, 2'd0, 16'h0000, 1'b0, 1'b0, 8'h00}  // R9 no strobe
    };

    task automatic drive(input logic [1:0] op, input logic [15:0] a);
        @(posedge clk);
        #1;
        addr  = a;
        rd_en = (op == 2'd1);
        wr_en = (op == 2'd2);
        @(negedge clk);
    endtask

    task automatic chk(input int req, input string what, input logic [9:0] got, input logic [9:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state of level outputs
        chk(1, "levels after reset", {7'd0, col_wide, glyph_alt, page_two}, 10'd0);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            drive(v[27:26], v[25:10]);
            chk(int'(v[31:28]), "vector", {bank_rd_aux, bank_wr_aux, stat_data}, v[9:0]);
        end

        // R10 col_wide unchanged during its own write, set afterwards (R2)
        drive(2'd2, 16'hC00D);
        chk(10, "col_wide during write", {9'd0, col_wide}, 10'd0);
        drive(2'd0, 16'h0000);
        chk(2, "col_wide after write", {9'd0, col_wide}, 10'd1);
        drive(2'd2, 16'hC00F);
        drive(2'd0, 16'h0000);
        chk(2, "glyph_alt set", {9'd0, glyph_alt}, 10'd1);
        drive(2'd2, 16'hC00E);
        drive(2'd0, 16'h0000);
        chk(2, "glyph_alt clear", {9'd0, glyph_alt}, 10'd0);
        drive(2'd1, 16'hC055);
        drive(2'd0, 16'h0000);
        chk(7, "page_two output", {9'd0, page_two}, 10'd1);

        // R1 reset mid-run clears everything
        #1 rst_n = 1'b0;
        #20 rst_n = 1'b1;
        drive(2'd1, 16'hC018);
        chk(1, "status after reset", {2'b00, stat_data}, 10'd0);
        drive(2'd1, 16'h0000);
        chk(1, "zp after reset", {bank_rd_aux, 1'b0, stat_data}, 10'd0);
        chk(1, "levels after reset", {7'd0, col_wide, glyph_alt, page_two}, 10'd0);
        drive(2'd0, 16'h0000);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_bad++;
                $display("FAIL R0 watchdog: got timeout expected completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule